// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Vector Unit

This unit gathers the one-cycle event pulses of an I2C master controller core into a sticky 16-bit status word. It holds an interrupt mask word beside it and drives one level interrupt line toward the processor. Software clears status flags by writing ones to them. The bus-busy flag is the exception: it is a live copy of the controller's bus-busy level and cannot be cleared.

For software written around an older, vectored style of service, a third register reports the most urgent pending and enabled event as a small code. Reading that register acknowledges the event it reported.

The register port is a plain synchronous 16-bit read/write interface with a word address. Read data is combinational from the selected register. Side effects of writes and vector reads take place at the clock edge on which the strobe is high.

Top module: `i2cm_event_hub`

## Requirements
- R1: While reset is asserted and after its release, the status word, the mask word, the vector code and `irq_o` are all zero.
- R2: An event pulse on `evt_i[b]` sets status bit b at the next clock edge, and the bit holds until it is cleared. The settable positions are 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 10 transmit underflow, 11 receive overrun, 13 receive drain and 14 transmit drain. The status word is read at word address 0.
- R3: A write to address 0 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event pulse and a clear of the same status bit, by write or by vector read, occur in the same cycle, the bit is set after the edge.
- R5: Status bit 12 shows `bus_busy_i` as sampled at the previous clock edge. Writing 1 to it has no effect.
- R6: The mask word at address 1 stores write-data bits 0 to 4, 13 and 14 and reads 0 elsewhere. Status bits 5 to 9 and 15 always read 0, whatever is driven on `evt_i`.
- R7: `irq_o` equals, one cycle later, the OR over all bits of (status AND mask).
- R8: Writing 0 to the mask word drops `irq_o` one cycle after the write takes effect and leaves the status bits unchanged.
- R9: Address 2 reads the vector code in bits 2:0, with the upper bits 0. The code is 0 when no event is pending and enabled. Otherwise it is 1 for arbitration lost, 2 for no-acknowledge, 3 for access ready, 4 for receive ready and 5 for transmit ready, counting only bits 0 to 4 that are both set and enabled. The lowest nonzero code wins.
- R10: A read strobe at address 2 clears the status bit behind the reported code at the edge and no other bit.
- R11: Writes to address 2 or 3 change no state, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | One-cycle event pulses, aligned to status bit positions |
| bus_busy_i | input | 1 | Live bus-busy level from the controller core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect only at address 2) |
| reg_addr_i | input | 2 | Word address: 0 status, 1 mask, 2 vector |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench aims at a pulse landing on the very edge that clears its bit. A design that lets the clear win there would silently lose an event. Bus busy is written with a one while the line is high, which catches a design that lets software clear a live level. The vector is drained with several events pending, to expose a wrong priority order and a read that clears more than the reported bit or the wrong one. Finally, the mask is dropped with events still pending, so that a design which wipes the status instead of only gating the interrupt line is caught. Long random runs mixing writes, vector reads and dense pulses then compare every read and the interrupt line against a cycle model.

// File: rtl/evh_pkg.sv
package evh_pkg;
    localparam int unsigned REG_W = 16;

    localparam int unsigned B_ARB  = 0;
    localparam int unsigned B_NACK = 1;
    localparam int unsigned B_ARDY = 2;
    localparam int unsigned B_RRDY = 3;
    localparam int unsigned B_XRDY = 4;
    localparam int unsigned B_XUDF = 10;
    localparam int unsigned B_ROVR = 11;
    localparam int unsigned B_BUSY = 12;
    localparam int unsigned B_RDRN = 13;
    localparam int unsigned B_XDRN = 14;

    // event-settable status positions
    localparam logic [REG_W-1:0] EVT_MASK =
        (REG_W'(1) << B_ARB)  | (REG_W'(1) << B_NACK) | (REG_W'(1) << B_ARDY) |
        (REG_W'(1) << B_RRDY) | (REG_W'(1) << B_XRDY) | (REG_W'(1) << B_XUDF) |
        (REG_W'(1) << B_ROVR) | (REG_W'(1) << B_RDRN) | (REG_W'(1) << B_XDRN);

    // implemented mask-word positions
    localparam logic [REG_W-1:0] EN_MASK =
        (REG_W'(1) << B_ARB)  | (REG_W'(1) << B_NACK) | (REG_W'(1) << B_ARDY) |
        (REG_W'(1) << B_RRDY) | (REG_W'(1) << B_XRDY) | (REG_W'(1) << B_RDRN) |
        (REG_W'(1) << B_XDRN);

    localparam int unsigned OFS_STAT = 0;
    localparam int unsigned OFS_EN   = 1;
    localparam int unsigned OFS_VEC  = 2;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] en;
        logic             irq;
    } evh_state_t;
endpackage

// File: rtl/evh_vec_enc.sv
module evh_vec_enc #(
    parameter int unsigned N_SRC  = 5,
    parameter int unsigned CODE_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0]  pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N_SRC-1:0]  sel_o
);
    // scan from the top so the lowest pending source is the last to land
    always_comb begin
        code_o = '0;
        sel_o  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o   = CODE_W'(i + 1);
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evh_stat_next.sv
module evh_stat_next
    import evh_pkg::*;
(
    input  logic [REG_W-1:0] stat_q_i,
    input  logic [REG_W-1:0] evt_i,
    input  logic             busy_i,
    input  logic [REG_W-1:0] w1c_i,
    input  logic [REG_W-1:0] vclr_i,
    output logic [REG_W-1:0] stat_d_o
);
    logic [REG_W-1:0] kept;
    logic [REG_W-1:0] sticky;

    // clears act on the held value only; a fresh pulse is ORed after them
    assign kept     = stat_q_i & ~w1c_i & ~vclr_i;
    assign sticky   = (kept | evt_i) & EVT_MASK;
    assign stat_d_o = sticky | (REG_W'(busy_i) << B_BUSY);
endmodule

// File: rtl/i2cm_event_hub.sv
module i2cm_event_hub
    import evh_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned N_VEC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       evt_i,
    input  logic              bus_busy_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam int unsigned CODE_W = $clog2(N_VEC + 1);

    evh_state_t s_q, s_d;

    logic              sel_stat, sel_en, sel_vec;
    logic [N_VEC-1:0]  vec_pend, vec_sel;
    logic [CODE_W-1:0] vec_code;
    logic [REG_W-1:0]  w1c_mask, vclr_mask, stat_nxt;

    assign sel_stat = (reg_addr_i == ADDR_W'(OFS_STAT));
    assign sel_en   = (reg_addr_i == ADDR_W'(OFS_EN));
    assign sel_vec  = (reg_addr_i == ADDR_W'(OFS_VEC));

    assign vec_pend = s_q.stat[N_VEC-1:0] & s_q.en[N_VEC-1:0];

    evh_vec_enc #(
        .N_SRC  (N_VEC),
        .CODE_W (CODE_W)
    ) u_enc (
        .pend_i (vec_pend),
        .code_o (vec_code),
        .sel_o  (vec_sel)
    );

    assign w1c_mask = (reg_wr_i && sel_stat) ? reg_wdata_i : '0;

    always_comb begin
        vclr_mask = '0;
        if (reg_rd_i && sel_vec) begin
            vclr_mask[N_VEC-1:0] = vec_sel;
        end
    end

    evh_stat_next u_nxt (
        .stat_q_i (s_q.stat),
        .evt_i    (evt_i),
        .busy_i   (bus_busy_i),
        .w1c_i    (w1c_mask),
        .vclr_i   (vclr_mask),
        .stat_d_o (stat_nxt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.stat = stat_nxt;
        if (reg_wr_i && sel_en) begin
            s_d.en = reg_wdata_i & EN_MASK;
        end
        s_d.irq  = |(s_q.stat & s_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (sel_stat) begin
            reg_rdata_o = s_q.stat;
        end else if (sel_en) begin
            reg_rdata_o = s_q.en;
        end else if (sel_vec) begin
            reg_rdata_o = {{(REG_W - CODE_W){1'b0}}, vec_code};
        end
    end

    assign irq_o = s_q.irq;
endmodule

// File: rtl/evh_checker.sv
module evh_checker
    import evh_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       evt_i,
    input logic              bus_busy_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [15:0]       reg_wdata_i,
    input logic [15:0]       reg_rdata_o,
    input logic              irq_o,
    input logic [15:0]       stat_q,
    input logic [15:0]       en_q
);
    // R2 / R4: a pulse always lands, even against a clear
    a_r4_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_i & EVT_MASK) != '0) |=>
        ((stat_q & $past(evt_i & EVT_MASK)) == $past(evt_i & EVT_MASK)));

    // R3: written ones clear bits that saw no pulse
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(OFS_STAT)) |=>
        ((stat_q & $past(reg_wdata_i & ~evt_i & EVT_MASK)) == '0));

    // R5: busy tracks the input with one cycle of delay
    a_r5_busy_live: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stat_q[B_BUSY] == $past(bus_busy_i)));

    // R6: unimplemented positions stay zero
    a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~(EVT_MASK | (16'd1 << B_BUSY))) == '0) && ((en_q & ~EN_MASK) == '0));

    // R7: interrupt line follows masked status one cycle later
    a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) != '0) |=> irq_o);
    a_r7_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) |=> !irq_o);

    // R9: enabled arbitration loss is always reported as code 1
    a_r9_top_code: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(OFS_VEC) && stat_q[B_ARB] && en_q[B_ARB]) |->
        (reg_rdata_o == 16'd1));

    // R10: a vector read of code 1 acknowledges the arbitration flag
    a_r10_vec_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(OFS_VEC) && stat_q[B_ARB] && en_q[B_ARB]
         && !evt_i[B_ARB]) |=> !stat_q[B_ARB]);
endmodule

bind i2cm_event_hub evh_checker #(.ADDR_W(ADDR_W)) u_evh_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .bus_busy_i  (bus_busy_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .stat_q      (s_q.stat),
    .en_q        (s_q.en)
);

// File: tb/test_i2cm_event_hub.sv
`timescale 1ns/1ps
module test_i2cm_event_hub;
    localparam logic [15:0] SET_BITS = 16'h6C1F;
    localparam logic [15:0] EN_BITS  = 16'h601F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_stat = '0;
    logic [15:0] m_en = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    i2cm_event_hub i_i2cm_event_hub (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .bus_busy_i  (bus_busy_i),
        .reg_wr_i    (reg_wr_i),
        .reg_rd_i    (reg_rd_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    function automatic logic [2:0] exp_code(input logic [15:0] st, input logic [15:0] en);
        for (int i = 0; i < 5; i++) begin
            if (st[i] && en[i]) return 3'(i + 1);
        end
        return 3'd0;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_stat;
            2'd1:    return m_en;
            2'd2:    return {13'd0, exp_code(m_stat, m_en)};
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive after the falling edge, check before the rising edge
    task automatic cycle(input logic [15:0] evt, input logic wr, input logic rd,
                         input logic [1:0] addr, input logic [15:0] wdata, input string tag);
        logic [2:0]  code;
        logic [15:0] vclr, w1c, n_stat;
        evt_i = evt; reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = addr; reg_wdata_i = wdata;
        #1;
        check(tag, reg_rdata_o, exp_rdata(addr));
        check((tag == "R8") ? "R8" : "R7", {15'd0, irq_o}, {15'd0, m_irq});
        code = exp_code(m_stat, m_en);
        vclr = (rd && addr == 2'd2 && code != 3'd0) ? (16'd1 << (code - 3'd1)) : 16'd0;
        w1c  = (wr && addr == 2'd0) ? wdata : 16'd0;
        n_stat = ((m_stat & ~w1c & ~vclr) | evt) & SET_BITS;
        n_stat[12] = bus_busy_i;
        m_irq = |(m_stat & m_en);
        m_stat = n_stat;
        if (wr && addr == 2'd1) m_en = wdata & EN_BITS;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_read(input logic [1:0] addr, input string tag);
        cycle(16'd0, 1'b0, 1'b0, addr, 16'd0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 during reset
        evt_i = 16'hFFFF;
        #1;
        check("R1", reg_rdata_o, 16'd0);
        check("R1", {15'd0, irq_o}, 16'd0);
        evt_i = '0;
        rst_n = 1'b1;
        @(negedge clk);
        idle_read(2'd1, "R1");
        idle_read(2'd2, "R1");
        idle_read(2'd0, "R1");

        // R2: receive-ready pulse sticks
        cycle(16'h0008, 1'b0, 1'b0, 2'd0, 16'd0, "R2");
        idle_read(2'd0, "R2");
        idle_read(2'd0, "R2");
        // R3: zero-write keeps, one-write clears
        cycle(16'd0, 1'b1, 1'b0, 2'd0, 16'h0001, "R3");
        idle_read(2'd0, "R3");
        cycle(16'd0, 1'b1, 1'b0, 2'd0, 16'h0008, "R3");
        idle_read(2'd0, "R3");
        // R4: underflow pulse collides with its clear
        cycle(16'h0400, 1'b0, 1'b0, 2'd0, 16'd0, "R4");
        cycle(16'h0400, 1'b1, 1'b0, 2'd0, 16'h0400, "R4");
        idle_read(2'd0, "R4");
        cycle(16'd0, 1'b1, 1'b0, 2'd0, 16'h0400, "R4");
        // R5: busy live and not clearable
        bus_busy_i = 1'b1;
        idle_read(2'd0, "R5");
        cycle(16'd0, 1'b1, 1'b0, 2'd0, 16'h1000, "R5");
        idle_read(2'd0, "R5");
        bus_busy_i = 1'b0;
        idle_read(2'd0, "R5");
        idle_read(2'd0, "R5");
        // R6: reserved bits
        cycle(16'd0, 1'b1, 1'b0, 2'd1, 16'hFFFF, "R6");
        idle_read(2'd1, "R6");
        cycle(16'hFFFF, 1'b0, 1'b0, 2'd0, 16'd0, "R6");
        idle_read(2'd0, "R6");
        idle_read(2'd0, "R7");
        // R8: mask off keeps status, drops irq
        cycle(16'd0, 1'b1, 1'b0, 2'd1, 16'h0000, "R8");
        idle_read(2'd0, "R8");
        idle_read(2'd0, "R8");
        cycle(16'd0, 1'b1, 1'b0, 2'd0, 16'hFFFF, "R8");
        // R9/R10: drain the vector with NACK, RX ready and TX ready pending
        cycle(16'd0, 1'b1, 1'b0, 2'd1, 16'h001F, "R9");
        cycle(16'h001A, 1'b0, 1'b0, 2'd2, 16'd0, "R9");
        cycle(16'd0, 1'b0, 1'b1, 2'd2, 16'd0, "R9");
        cycle(16'd0, 1'b0, 1'b1, 2'd2, 16'd0, "R10");
        idle_read(2'd0, "R10");
        cycle(16'd0, 1'b0, 1'b1, 2'd2, 16'd0, "R10");
        idle_read(2'd2, "R10");
        // R11: vector and spare addresses take no writes
        cycle(16'h0004, 1'b0, 1'b0, 2'd0, 16'd0, "R11");
        cycle(16'd0, 1'b1, 1'b0, 2'd2, 16'hFFFF, "R11");
        cycle(16'd0, 1'b1, 1'b0, 2'd3, 16'hFFFF, "R11");
        idle_read(2'd0, "R11");
        idle_read(2'd1, "R11");
        idle_read(2'd3, "R11");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] ev;
            logic [1:0]  ad;
            logic        w, r;
            ev = 16'($urandom & $urandom & $urandom);
            ad = 2'($urandom);
            w  = ($urandom % 4) == 0;
            r  = ($urandom % 3) == 0;
            if (($urandom % 16) == 0) bus_busy_i = ~bus_busy_i;
            cycle(ev, w, r, ad, 16'($urandom),
                  (ad == 2'd0) ? "R3" : (ad == 2'd1) ? "R6" : (ad == 2'd2) ? "R10" : "R11");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule